// File: doc/BRIEF.md
# Frame Pulse Period Monitor

This block watches the frame-pulse input of a transmit system bus. It checks that successive pulses are a whole number of frame periods apart, counted in bus clocks. The nominal frame lasts 125 µs. That is 1024 clocks at the single bus rate and 2048 clocks when the bus clock runs at twice the data rate. When the monitor is told that the pulse marks only the first frame of each multiframe, the spacing must instead be a whole number of multiframes.

The input can be taken as active high or active low. It can be captured on the rising or the falling clock edge. In double-clock mode only the first edge of each two-clock bit period is used. Any spacing that is not a whole multiple sets a sticky error flag, which stays set until a clear strobe. An interrupt output shows the flag whenever the interrupt enable is set. The pulse that follows reset only establishes the reference point and is never judged.

The block has no data stream, so every pin is a plain level or strobe. No valid/ready handshake applies, and no back-pressure exists.

Top module: `tx_fp_period_mon`

## Requirements
- R1: After reset, err_flag and irq are 0.
- R2: The first pulse seen after reset never sets err_flag, whatever time has passed since reset.
- R3: With cfg_dbl=0 and cfg_mf=0, a pulse that starts a whole multiple of FRAME_CLKS clocks after the previous pulse (1, 2 or 3 frames) does not set err_flag.
- R4: A pulse whose spacing from the previous pulse is not a whole multiple of the required period sets err_flag. The flag is visible at most two clocks after the sampling edge that sees the pulse.
- R5: err_flag stays 1 until err_clr is high on a rising clock edge, and that edge returns it to 0 unless a new error is found in the same cycle.
- R6: irq is 1 exactly when err_flag is 1 and irq_en is 1.
- R7: With cfg_inv=1 the pulse is active low: a 1-to-0 transition of fp_in starts a pulse. With cfg_inv=0 a 0-to-1 transition starts it.
- R8: With cfg_mf=1 the required period is MF_FRAMES frames. A spacing of one frame is then an error, and spacings of MF_FRAMES or 2*MF_FRAMES frames are not.
- R9: With cfg_dbl=1 a frame is 2*FRAME_CLKS clocks. fp_in is sampled only on every second rising edge, counting the first edge after reset release as a sampling edge. A two-clock pulse spaced one single-rate frame (FRAME_CLKS clocks) from the previous one is an error.
- R10: With cfg_fall=1, fp_in is captured on the falling clock edge, so a pulse that spans no falling edge is ignored. With cfg_fall=0 it is captured on the rising edge.
- R11: The period counter never reaches the selected period, and it covers FRAME_CLKS*2*MF_FRAMES clocks without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fp_in | input | 1 | Frame pulse from the system bus |
| cfg_inv | input | 1 | 1: pulse is active low |
| cfg_fall | input | 1 | 1: capture fp_in on the falling edge |
| cfg_dbl | input | 1 | 1: bus clock runs at twice the bit rate |
| cfg_mf | input | 1 | 1: pulse marks the first frame of each multiframe only |
| irq_en | input | 1 | Interrupt enable |
| err_clr | input | 1 | Clear strobe for err_flag |
| err_flag | output | 1 | Sticky spacing-error flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the monitor with FRAME_CLKS=16 and MF_FRAMES=4. A frame is then 16 or 32 clocks and a multiframe 64 clocks. This makes spacings of one, two and three frames, whole multiframes, and off-by-a-few misalignments cheap to drive in every mode. At these sizes the bench can reset between scenarios and give each mode combination (inverted polarity, multiframe, double clock, falling-edge capture) a clean reference pulse.

// File: rtl/fpm_pkg.sv
`timescale 1ns/1ps
package fpm_pkg;

  typedef enum logic {
    CAP_RISE = 1'b0,
    CAP_FALL = 1'b1
  } fpm_cap_e;

  // Clocks between legal pulses for the selected mode.
  function automatic int unsigned fpm_period(
    input int unsigned frame_clks,
    input int unsigned mf_frames,
    input logic        dbl,
    input logic        mfsel
  );
    int unsigned p;
    p = frame_clks;
    if (dbl)   p = p * 2;
    if (mfsel) p = p * mf_frames;
    return p;
  endfunction

endpackage

// File: rtl/fpm_sampler.sv
`timescale 1ns/1ps
module fpm_sampler
  import fpm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fp_in,
  input  logic cfg_inv,
  input  logic cfg_fall,
  input  logic cfg_dbl,
  output logic pulse
);

  logic     fp_neg;
  logic     phase;
  logic     last_act;
  logic     take;
  logic     act;
  fpm_cap_e cap_sel;

  // falling-edge capture path
  always_ff @(negedge clk) begin
    fp_neg <= fp_in;
  end

  assign cap_sel = fpm_cap_e'(cfg_fall);
  assign act     = ((cap_sel == CAP_FALL) ? fp_neg : fp_in) ^ cfg_inv;
  assign take    = !cfg_dbl || !phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= 1'b0;
      last_act <= 1'b0;
      pulse    <= 1'b0;
    end else begin
      phase <= ~phase;
      if (take) begin
        last_act <= act;
        pulse    <= act & ~last_act;
      end else begin
        pulse    <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/fpm_period_chk.sv
`timescale 1ns/1ps
module fpm_period_chk #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pulse,
  input  logic [CW-1:0] period,
  output logic          pulse_err,
  output logic          armed,
  output logic [CW-1:0] cnt
);

  localparam logic [CW-1:0] ONE = CW'(1);

  // cnt is clocks since the last pulse, modulo period
  assign pulse_err = pulse && armed && (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else begin
      if (pulse) begin
        armed <= 1'b1;
        cnt   <= ONE;
      end else if (cnt >= period - ONE) begin
        cnt   <= '0;
      end else begin
        cnt   <= cnt + ONE;
      end
    end
  end

endmodule

// File: rtl/fpm_status.sv
`timescale 1ns/1ps
module fpm_status (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_err,
  input  logic err_clr,
  input  logic irq_en,
  output logic err_flag,
  output logic irq
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         err_flag <= 1'b0;
    else if (pulse_err) err_flag <= 1'b1;
    else if (err_clr)   err_flag <= 1'b0;
  end

  assign irq = err_flag & irq_en;

endmodule

// File: rtl/tx_fp_period_mon.sv
`timescale 1ns/1ps
module tx_fp_period_mon
  import fpm_pkg::*;
#(
  parameter int FRAME_CLKS = 1024,
  parameter int MF_FRAMES  = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fp_in,
  input  logic cfg_inv,
  input  logic cfg_fall,
  input  logic cfg_dbl,
  input  logic cfg_mf,
  input  logic irq_en,
  input  logic err_clr,
  output logic err_flag,
  output logic irq
);

  localparam int MAX_PERIOD = FRAME_CLKS * 2 * MF_FRAMES;
  localparam int CW         = $clog2(MAX_PERIOD + 1);

  logic          pulse;
  logic          pulse_err;
  logic          armed;
  logic [CW-1:0] cnt;
  logic [CW-1:0] period;

  assign period = CW'(fpm_period(FRAME_CLKS, MF_FRAMES, cfg_dbl, cfg_mf));

  fpm_sampler u_smp (
    .clk      (clk),
    .rst_n    (rst_n),
    .fp_in    (fp_in),
    .cfg_inv  (cfg_inv),
    .cfg_fall (cfg_fall),
    .cfg_dbl  (cfg_dbl),
    .pulse    (pulse)
  );

  fpm_period_chk #(.CW(CW)) u_per (
    .clk       (clk),
    .rst_n     (rst_n),
    .pulse     (pulse),
    .period    (period),
    .pulse_err (pulse_err),
    .armed     (armed),
    .cnt       (cnt)
  );

  fpm_status u_st (
    .clk       (clk),
    .rst_n     (rst_n),
    .pulse_err (pulse_err),
    .err_clr   (err_clr),
    .irq_en    (irq_en),
    .err_flag  (err_flag),
    .irq       (irq)
  );

endmodule

// File: rtl/fpm_checker.sv
`timescale 1ns/1ps
module fpm_checker #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_dbl,
  input logic          irq_en,
  input logic          err_clr,
  input logic          err_flag,
  input logic          irq,
  input logic          pulse,
  input logic          pulse_err,
  input logic          armed,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] period
);

  AST_UNARMED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !pulse_err);  // R2

  AST_ERR_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_err |=> err_flag);  // R4

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag && !err_clr |=> err_flag);  // R5

  AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr && !pulse_err |=> !err_flag);  // R5

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> irq_en);  // R6

  AST_DBL_ALT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_dbl && pulse |=> !pulse);  // R9

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < period);  // R11

endmodule

bind tx_fp_period_mon fpm_checker #(.CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_dbl   (cfg_dbl),
  .irq_en    (irq_en),
  .err_clr   (err_clr),
  .err_flag  (err_flag),
  .irq       (irq),
  .pulse     (pulse),
  .pulse_err (pulse_err),
  .armed     (armed),
  .cnt       (cnt),
  .period    (period)
);

// File: tb/tx_fp_period_mon_tb.sv
`timescale 1ns/1ps
module tx_fp_period_mon_tb;

  localparam int FR = 16;
  localparam int MF = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fp_in = 1'b0;
  logic cfg_inv = 1'b0, cfg_fall = 1'b0, cfg_dbl = 1'b0, cfg_mf = 1'b0;
  logic irq_en = 1'b0, err_clr = 1'b0;
  logic err_flag, irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [1:0] q_exp[$];
  string      q_tag[$];

  always #2.5 clk = ~clk;

  tx_fp_period_mon #(.FRAME_CLKS(FR), .MF_FRAMES(MF)) u_dut (
    .clk(clk), .rst_n(rst_n), .fp_in(fp_in), .cfg_inv(cfg_inv),
    .cfg_fall(cfg_fall), .cfg_dbl(cfg_dbl), .cfg_mf(cfg_mf),
    .irq_en(irq_en), .err_clr(err_clr), .err_flag(err_flag), .irq(irq)
  );

  // monitor: pop expected items and compare away from the rising edge
  always @(negedge clk) begin
    if (q_exp.size() > 0) begin
      logic [1:0] e;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      n_tests++;
      if ({err_flag, irq} !== e) begin
        n_fail++;
        $display("FAIL %s: flag=%0b irq=%0b expected flag=%0b irq=%0b",
                 t, err_flag, irq, e[1], e[0]);
      end
    end
  end

  task automatic do_reset(bit inv, bit fall, bit dbl, bit mf);
    @(posedge clk); #1;
    rst_n = 1'b0;
    cfg_inv = inv; cfg_fall = fall; cfg_dbl = dbl; cfg_mf = mf;
    fp_in = inv;
    err_clr = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
  endtask

  // pulse of w clocks; next call starts sp clocks after this one
  task automatic pulse_at(int sp, int w);
    fp_in = !cfg_inv;
    repeat (w) @(posedge clk);
    #1 fp_in = cfg_inv;
    repeat (sp - w) @(posedge clk);
    #1;
  endtask

  // pulse that covers a rising edge but no falling edge
  task automatic glitch();
    #2 fp_in = !cfg_inv;
    @(posedge clk);
    #1 fp_in = cfg_inv;
  endtask

  task automatic expect_st(bit ef, bit ei, string tag);
    repeat (4) @(posedge clk);
    #1;
    q_exp.push_back({ef, ei});
    q_tag.push_back(tag);
    @(negedge clk);
    @(posedge clk);
    #1;
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        if (!done) begin
          n_tests++; n_fail++;
          $display("FAIL watchdog: got timeout expected completion");
          $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
          $finish;
        end
      end
    join_none

    do_reset(0, 0, 0, 0);
    expect_st(0, 0, "R1 reset state");
    irq_en = 1'b1;

    // R2: first pulse only arms
    repeat (7) @(posedge clk);
    #1;
    pulse_at(FR, 1);
    expect_st(0, 0, "R2 first pulse");

    // R3: 1, 2, 3 frame spacings
    do_reset(0, 0, 0, 0);
    pulse_at(FR, 1); pulse_at(2*FR, 1); pulse_at(3*FR, 1); pulse_at(FR, 1);
    expect_st(0, 0, "R3 multiples of frame");

    // R4 / R5 / R6
    do_reset(0, 0, 0, 0);
    pulse_at(FR, 1); pulse_at(FR + 4, 1); pulse_at(FR, 1);
    expect_st(1, 1, "R4 misaligned spacing");
    expect_st(1, 1, "R5 flag sticky");
    irq_en = 1'b0;
    expect_st(1, 0, "R6 irq masked");
    err_clr = 1'b1;
    @(posedge clk); #1 err_clr = 1'b0;
    expect_st(0, 0, "R5 clear");
    irq_en = 1'b1;
    expect_st(0, 0, "R6 no flag no irq");

    // R7: active-low polarity
    do_reset(1, 0, 0, 0);
    pulse_at(FR, 1); pulse_at(FR, 1); pulse_at(2*FR, 1); pulse_at(FR, 1);
    expect_st(0, 0, "R7 active low aligned");
    do_reset(1, 0, 0, 0);
    pulse_at(FR, 1); pulse_at(7, 1); pulse_at(FR, 1);
    expect_st(1, 1, "R7 active low misaligned");

    // R8 / R11: multiframe
    do_reset(0, 0, 0, 1);
    pulse_at(FR, 1); pulse_at(FR, 1);
    expect_st(1, 1, "R8 one frame in multiframe mode");
    do_reset(0, 0, 0, 1);
    pulse_at(MF*FR, 1); pulse_at(2*MF*FR, 1); pulse_at(FR, 1);
    expect_st(0, 0, "R8 R11 whole multiframes");

    // R9: double clock
    do_reset(0, 0, 1, 0);
    pulse_at(2*FR, 2); pulse_at(4*FR, 2); pulse_at(2*FR, 2);
    expect_st(0, 0, "R9 double clock aligned");
    do_reset(0, 0, 1, 0);
    pulse_at(2*FR, 2); pulse_at(FR, 2); pulse_at(2*FR, 2);
    expect_st(1, 1, "R9 single-rate spacing in double mode");

    // R10: capture edge
    do_reset(0, 1, 0, 0);
    pulse_at(FR, 1); pulse_at(FR, 1); pulse_at(5, 1);
    glitch();
    expect_st(0, 0, "R10 falling capture ignores glitch");
    do_reset(0, 0, 0, 0);
    pulse_at(FR, 1); pulse_at(FR, 1); pulse_at(5, 1);
    glitch();
    expect_st(1, 1, "R10 rising capture sees glitch");

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule